// File: doc/BRIEF.md
# Byte Permute-and-Transform Unit

This block assembles a 128-bit result one byte lane at a time. Two 16-byte source vectors are concatenated into a 32-entry byte lookup table. A third 16-byte vector holds one control byte for each output lane. The control byte chooses a table entry, changes that byte in one of four ways, and can then invert it. Every lane computes its result on its own, so any lane can read any table entry, and several lanes can read the same entry.

Operands come in on a valid/ready handshake. The result is captured in an output register and offered on the cycle after the operands are accepted. The input side can take a new operand set on every cycle while the consumer keeps draining results. This gives one result per cycle at full throughput.

Top module: `bpt_permute_unit`

## Requirements
- R1: Control bits 4:0 form a table index. Indices 0 to 15 select byte 0 to 15 of `src_a`, and indices 16 to 31 select byte 0 to 15 of `src_b`. Byte k of any vector occupies bits 8k+7 down to 8k, and lane k takes its control byte from `ctrl` bits 8k+7 down to 8k.
- R2: When control bits 7:6 are 00, the selected byte passes through unchanged.
- R3: When control bits 7:6 are 01, the selected byte is bit-reversed, so bit i moves to bit 7-i.
- R4: When control bits 7:6 are 10, the byte becomes 0x00.
- R5: When control bits 7:6 are 11, all eight bits take the value of the selected byte's bit 7.
- R6: When control bit 5 is 1, the transformed byte is bitwise inverted. Inversion happens after the transform, so a zeroed byte becomes 0xFF.
- R7: Each output lane depends only on its own control byte and the two sources. Different lanes with different control bytes give independent results in the same transfer.
- R8: An operand set accepted on a clock edge (`in_valid` and `in_ready` both high) appears on `out_data` with `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, both `out_valid` and `out_data` hold their values.
- R9: `in_ready` is high when the output register is empty or when `out_ready` is high. It is low while a held result is stalled.
- R10: A synchronous active-high `rst` clears `out_valid`, including when a result is being held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set is present |
| in_ready | output | 1 | Unit can take an operand set this cycle |
| src_a | input | 8*LANES | Table entries 0 to LANES-1 |
| src_b | input | 8*LANES | Table entries LANES to 2*LANES-1 |
| ctrl | input | 8*LANES | One control byte per output lane |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 8*LANES | Result, one byte per lane |

## Verification
The bench builds the unit with its default of 16 lanes, which gives a 5-bit table index. Every one of the 256 control values is therefore meaningful, and a full sweep over them covers each index, each transform and each inversion setting. Each lane receives a different rotation of the sweep, so every lane sees all 256 values while its neighbours hold different codes. Sources are random on every transfer. Directed sequences then cover stalls with a competing operand set waiting, and a reset that arrives while a result is held.

// File: rtl/bpt_pkg.sv
package bpt_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef logic [BYTE_W-1:0] byte_t;

  // Transform codes carried in control bits 7:6
  typedef enum logic [1:0] {
    XF_PASS     = 2'd0,
    XF_REVERSE  = 2'd1,
    XF_CLEAR    = 2'd2,
    XF_SIGNFILL = 2'd3
  } xform_e;

  // Packed layout matches the control byte: [7:6] xform, [5] invert, [4:0] index
  typedef struct packed {
    xform_e      xform;
    logic        invert;
    logic [4:0]  index;
  } lane_ctl_t;

  function automatic byte_t reverse_byte(input byte_t b);
    byte_t r;
    for (int i = 0; i < BYTE_W; i++) begin
      r[i] = b[BYTE_W-1-i];
    end
    return r;
  endfunction

endpackage

// File: rtl/bpt_byte_pick.sv
module bpt_byte_pick
  import bpt_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES*BYTE_W-1:0] table_flat,
  input  logic [IDX_W-1:0]          sel,
  output byte_t                     picked
);

  always_comb begin
    picked = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (sel == IDX_W'(e)) begin
        picked = table_flat[e*BYTE_W +: BYTE_W];
      end
    end
  end

endmodule

// File: rtl/bpt_byte_xform.sv
module bpt_byte_xform
  import bpt_pkg::*;
(
  input  byte_t  raw,
  input  xform_e mode,
  input  logic   invert,
  output byte_t  result
);

  byte_t shaped;

  always_comb begin
    unique case (mode)
      XF_PASS:     shaped = raw;
      XF_REVERSE:  shaped = reverse_byte(raw);
      XF_CLEAR:    shaped = '0;
      XF_SIGNFILL: shaped = {BYTE_W{raw[BYTE_W-1]}};
      default:     shaped = raw;
    endcase
  end

  // Inversion is applied after the transform stage
  assign result = invert ? ~shaped : shaped;

endmodule

// File: rtl/bpt_out_stage.sv
module bpt_out_stage #(
  parameter int unsigned WIDTH = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_valid,
  output logic             load_ready,
  input  logic [WIDTH-1:0] load_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);

  logic             held_valid;
  logic [WIDTH-1:0] held_data;

  assign load_ready = !held_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_valid <= 1'b0;
    end else if (load_ready) begin
      held_valid <= load_valid;
    end
  end

  // Data register carries no reset so it maps onto plain fabric flops
  always_ff @(posedge clk) begin
    if (load_valid && load_ready) begin
      held_data <= load_data;
    end
  end

  assign out_valid = held_valid;
  assign out_data  = held_data;

endmodule

// File: rtl/bpt_permute_unit.sv
module bpt_permute_unit
  import bpt_pkg::*;
#(
  parameter int unsigned LANES = 16,
  localparam int unsigned VEC_W   = LANES * BYTE_W,
  localparam int unsigned ENTRIES = 2 * LANES,
  localparam int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  input  logic [VEC_W-1:0] ctrl,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_data
);

  // Entry 0 is src_a byte 0; entry LANES is src_b byte 0
  logic [2*VEC_W-1:0] byte_table;
  logic [VEC_W-1:0]   lane_results;

  assign byte_table = {src_b, src_a};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lane_ctl_t cfg;
    byte_t     picked;
    byte_t     shaped;

    assign cfg = lane_ctl_t'(ctrl[l*BYTE_W +: BYTE_W]);

    bpt_byte_pick #(
      .ENTRIES (ENTRIES)
    ) u_pick (
      .table_flat (byte_table),
      .sel        (cfg.index[IDX_W-1:0]),
      .picked     (picked)
    );

    bpt_byte_xform u_xform (
      .raw    (picked),
      .mode   (cfg.xform),
      .invert (cfg.invert),
      .result (shaped)
    );

    assign lane_results[l*BYTE_W +: BYTE_W] = shaped;
  end

  bpt_out_stage #(
    .WIDTH (VEC_W)
  ) u_stage (
    .clk        (clk),
    .rst        (rst),
    .load_valid (in_valid),
    .load_ready (in_ready),
    .load_data  (lane_results),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data)
  );

endmodule

// File: rtl/bpt_permute_checker.sv
module bpt_permute_checker #(
  parameter int unsigned LANES = 16,
  localparam int unsigned VEC_W = LANES * 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [VEC_W-1:0] src_a,
  input logic [VEC_W-1:0] ctrl,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VEC_W-1:0] out_data
);

  logic fire;
  logic rst_q = 1'b0;

  assign fire = in_valid && in_ready;

  always_ff @(posedge clk) begin
    rst_q <= rst;
  end

  // R10: a cycle after reset was sampled, no result is offered
  always @(posedge clk) begin
    if (rst_q) begin
      a_reset_clears_r10: assert (!out_valid);
    end
  end

  p_accept_shows_r8: assert property (@(posedge clk) disable iff (rst)
    fire |=> out_valid);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_stall_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  p_empty_ready_r9: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  p_pass_low_r2: assert property (@(posedge clk) disable iff (rst)
    (fire && ctrl[7:0] == 8'h00) |=> (out_data[7:0] == $past(src_a[7:0])));

  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (fire && ctrl[7:5] == 3'b100) |=> (out_data[7:0] == 8'h00));

  p_clear_inv_r6: assert property (@(posedge clk) disable iff (rst)
    (fire && ctrl[7:5] == 3'b101) |=> (out_data[7:0] == 8'hFF));

endmodule

bind bpt_permute_unit bpt_permute_checker #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .src_a     (src_a),
  .ctrl      (ctrl),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/bpt_permute_unit_tb.sv
module bpt_permute_unit_tb;

  localparam int LANES = 16;
  localparam int VW    = LANES * 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          out_ready = 1'b0;
  logic [VW-1:0] src_a = '0;
  logic [VW-1:0] src_b = '0;
  logic [VW-1:0] ctrl = '0;
  logic          in_ready;
  logic          out_valid;
  logic [VW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2ns clk = ~clk;

  bpt_permute_unit #(.LANES(LANES)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .src_a     (src_a),
    .src_b     (src_b),
    .ctrl      (ctrl),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: got %0d cycles exp fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [7:0] model_lane(input logic [VW-1:0] a, input logic [VW-1:0] b,
                                            input logic [7:0] c);
    logic [7:0] s;
    logic [7:0] t;
    int idx;
    idx = int'(c[4:0]);
    s = (idx < LANES) ? a[idx*8 +: 8] : b[(idx-LANES)*8 +: 8];
    case (c[7:6])
      2'd0: t = s;
      2'd1: for (int i = 0; i < 8; i++) t[i] = s[7-i];
      2'd2: t = 8'h00;
      default: t = {8{s[7]}};
    endcase
    return c[5] ? ~t : t;
  endfunction

  function automatic string tag_for(input logic [7:0] c);
    string s;
    case (c[7:6])
      2'd0: s = "R1 R7 R2";
      2'd1: s = "R1 R7 R3";
      2'd2: s = "R1 R7 R4";
      default: s = "R1 R7 R5";
    endcase
    if (c[5]) s = {s, " R6"};
    return s;
  endfunction

  task automatic check_bit(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b exp %0b", tag, got, exp);
    end
  endtask

  task automatic check_lanes(input logic [VW-1:0] a, input logic [VW-1:0] b,
                             input logic [VW-1:0] c);
    for (int l = 0; l < LANES; l++) begin
      logic [7:0] cb;
      logic [7:0] exp;
      cb  = c[l*8 +: 8];
      exp = model_lane(a, b, cb);
      checks++;
      if (out_data[l*8 +: 8] !== exp) begin
        errors++;
        $display("FAIL %s lane %0d ctrl %02h: got %02h exp %02h",
                 tag_for(cb), l, cb, out_data[l*8 +: 8], exp);
      end
    end
  endtask

  function automatic logic [VW-1:0] rand_vec();
    logic [VW-1:0] v;
    for (int w = 0; w < VW/32; w++) v[w*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    logic [VW-1:0] pa, pb, pc, xa, xb, xc;

    // Reset state, R10
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_bit("R10 out_valid after reset", out_valid, 1'b0);
    check_bit("R9 in_ready when empty", in_ready, 1'b1);

    // Full sweep of control codes, streaming at one per cycle
    out_ready = 1'b1;
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      if (v > 0) begin
        check_bit("R8 out_valid streaming", out_valid, 1'b1);
        check_lanes(pa, pb, pc);
      end
      check_bit("R9 in_ready streaming", in_ready, 1'b1);
      pa = rand_vec();
      pb = rand_vec();
      for (int l = 0; l < LANES; l++) pc[l*8 +: 8] = 8'((v + l * 37) % 256);
      src_a = pa; src_b = pb; ctrl = pc; in_valid = 1'b1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    check_bit("R8 last of sweep valid", out_valid, 1'b1);
    check_lanes(pa, pb, pc);
    @(negedge clk);
    check_bit("R8 drained", out_valid, 1'b0);

    // Directed R6: zero plus inversion gives FF in every lane
    pa = rand_vec(); pb = rand_vec(); pc = {LANES{8'hA0}};
    src_a = pa; src_b = pb; ctrl = pc; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (out_data !== {LANES{8'hFF}}) begin
      errors++;
      $display("FAIL R6 clear+invert: got %h exp all FF", out_data);
    end

    // Directed R1 boundaries: indices 0, 15, 16, 31 and lane-to-source-byte mapping
    pa = rand_vec(); pb = rand_vec();
    for (int l = 0; l < LANES; l++) begin
      case (l % 4)
        0: pc[l*8 +: 8] = 8'd0;
        1: pc[l*8 +: 8] = 8'd15;
        2: pc[l*8 +: 8] = 8'd16;
        default: pc[l*8 +: 8] = 8'd31;
      endcase
    end
    src_a = pa; src_b = pb; ctrl = pc; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_lanes(pa, pb, pc);
    check_bit("R1 lane1 is src_a byte15", out_data[15:8] == pa[127:120], 1'b1);
    check_bit("R1 lane2 is src_b byte0", out_data[23:16] == pb[7:0], 1'b1);

    // Backpressure with a competing operand set, R8 and R9
    @(negedge clk);
    out_ready = 1'b0;
    pa = rand_vec(); pb = rand_vec(); pc = rand_vec();
    src_a = pa; src_b = pb; ctrl = pc; in_valid = 1'b1;
    @(negedge clk);
    xa = rand_vec(); xb = rand_vec(); xc = rand_vec();
    src_a = xa; src_b = xb; ctrl = xc;
    for (int k = 0; k < 3; k++) begin
      check_bit("R8 held valid under stall", out_valid, 1'b1);
      check_bit("R9 in_ready low under stall", in_ready, 1'b0);
      check_lanes(pa, pb, pc);
      @(negedge clk);
    end
    out_ready = 1'b1;
    #0.1ns;
    check_bit("R9 in_ready with out_ready", in_ready, 1'b1);
    check_lanes(pa, pb, pc);
    @(negedge clk);
    in_valid = 1'b0;
    check_bit("R8 second set valid", out_valid, 1'b1);
    check_lanes(xa, xb, xc);
    @(negedge clk);
    check_bit("R8 empty after drain", out_valid, 1'b0);

    // Reset while a result is held, R10
    out_ready = 1'b0;
    src_a = rand_vec(); src_b = rand_vec(); ctrl = rand_vec(); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_bit("R8 held before reset", out_valid, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_bit("R10 reset clears held result", out_valid, 1'b0);
    check_bit("R9 ready after reset", in_ready, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule